// File: doc/BRIEF.md
# USB On-The-Go Host Role Negotiator

This block runs the handshake by which two dual-role USB ports swap the host and device roles on a live link. An instance is set up as either the A side, which starts as host, or the B side, which starts as device. A single configuration input picks the side. The side that is not selected is held in its starting state.

The B side asks for the host role only when all of these are true: the A side has granted it, the link is suspended, and the link runs at full speed. It asks by letting go of its D+ pull-up, which the A side sees as a disconnect. Software on the A side has already chosen how to answer:

- **Yield:** the A side clears its host enable and turns its own pull-up on, so it appears as a full-speed device.
- **Keep:** the A side drives resume for a set number of milliseconds and stays host.

When the B side sees the connect, it becomes host and drives bus reset for a set number of milliseconds before it uses the bus. If the B side sees resume, or no connect arrives within a timeout, it puts its pull-up back and stays device. Every duration is counted in pulses of a one-millisecond tick input.

Top module: `otg_role_swap`

## Requirements
- R1: After reset the A side has host_en=1, dp_pullup=0, drive_reset=0, drive_resume=0, is_host=1. The B side has host_en=0, dp_pullup=1, drive_reset=0, drive_resume=0, is_host=0.
- R2: The B side releases dp_pullup at the clock edge where b_req, hnp_en, suspended and full_speed are all 1. If any of them is 0, the request is ignored and the B side keeps its pull-up.
- R3: On a line_disc pulse while it is idle host and qualified (hnp_en, suspended and full_speed all 1) with a_yield=1, the A side goes to host_en=0, dp_pullup=1, is_host=0.
- R4: On the same qualified disconnect with a_yield=0, the A side asserts drive_resume and keeps host_en=1. It drops drive_resume once RESUME_MS ticks have been counted and stays host.
- R5: The A side ignores a disconnect while it is not qualified: it stays host with its pull-up off.
- R6: While waiting after its request, a line_conn pulse makes the B side host (host_en=1, is_host=1) with drive_reset=1. drive_reset clears on the RESET_MS-th tick, and the B side stays host.
- R7: If the B side sees no connect within CONN_TMO_MS ticks of its request, it restores dp_pullup and stays device.
- R8: A line_resume pulse while the B side is waiting restores dp_pullup and keeps it device.
- R9: is_host is 1 exactly when the selected side holds the host role. A side acting as host never enables dp_pullup.
- R10: A connect on the same cycle as the final timeout tick counts as a connect. The reset period then counts a full RESET_MS ticks from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_role_b | input | 1 | 1 = B side, 0 = A side |
| hnp_en | input | 1 | Role swap granted by the A side |
| suspended | input | 1 | Link is in suspend |
| full_speed | input | 1 | Link runs at full speed |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| b_req | input | 1 | B side software asks for the host role |
| a_yield | input | 1 | A side answers a disconnect by yielding (1) or by resume (0) |
| line_disc | input | 1 | Disconnect seen on the line (pulse) |
| line_conn | input | 1 | Connect seen on the line (pulse) |
| line_resume | input | 1 | Resume seen on the line (pulse) |
| host_en | output | 1 | Host function enabled |
| dp_pullup | output | 1 | D+ pull-up enabled |
| drive_reset | output | 1 | Drive bus reset |
| drive_resume | output | 1 | Drive resume signaling |
| is_host | output | 1 | Current role, 1 = host |

## Verification
The bench sweeps every combination of the three qualifiers with the request on the B side, and every qualifier combination with a disconnect on the A side. A gate that drops one qualifier would let a request through where the bench expects the pull-up to stay on. The timeout is checked one tick before and at its limit, so a counter that is off by one shows up at once. The bench also drives a connect together with the final timeout tick. A design that lets the timeout win would fall back to device there, and one that does not restart its counter would end the reset early.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

    typedef enum logic [1:0] {
        A_HOST_IDLE,
        A_SEND_RESUME,
        A_AS_DEVICE
    } a_state_e;

    typedef enum logic [1:0] {
        B_AS_DEVICE,
        B_AWAIT_CONN,
        B_BUS_RESET,
        B_AS_HOST
    } b_state_e;

    // Line control bundle produced by each side
    typedef struct packed {
        logic host_en;
        logic dp_pullup;
        logic drive_reset;
        logic drive_resume;
        logic is_host;
    } line_ctl_t;

endpackage

// File: rtl/otg_ms_timer.sv
module otg_ms_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    assign expire = run && tick && (r_q.cnt == limit - TW'(1));

    always_comb begin
        r_d = r_q;
        if (!run || clr) begin
            r_d.cnt = '0;
        end else if (tick) begin
            r_d.cnt = expire ? '0 : r_q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (r_q.cnt < limit)); // R7

endmodule

// File: rtl/otg_a_side.sv
module otg_a_side
    import otg_role_pkg::*;
#(
    parameter int TW        = 5,
    parameter int RESUME_MS = 20
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      qualified,
    input  logic      line_disc,
    input  logic      a_yield,
    input  logic      ms_tick,
    output line_ctl_t ctl
);
    typedef struct packed {
        a_state_e st;
    } a_reg_t;

    a_reg_t s_d, s_q;
    logic   tmr_run, tmr_clr, tmr_done;

    assign tmr_run = (s_q.st == A_SEND_RESUME);
    assign tmr_clr = (s_d.st != s_q.st);

    otg_ms_timer #(.TW(TW)) i_resume_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clr    (tmr_clr),
        .tick   (ms_tick),
        .limit  (TW'(RESUME_MS)),
        .expire (tmr_done)
    );

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.st = A_HOST_IDLE;
        end else begin
            case (s_q.st)
                A_HOST_IDLE: begin
                    if (line_disc && qualified) begin
                        s_d.st = a_yield ? A_AS_DEVICE : A_SEND_RESUME;
                    end
                end
                A_SEND_RESUME: begin
                    if (tmr_done) s_d.st = A_HOST_IDLE;
                end
                A_AS_DEVICE: s_d.st = A_AS_DEVICE;
                default:     s_d.st = A_HOST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= A_HOST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl = '0;
        case (s_q.st)
            A_HOST_IDLE: begin
                ctl.host_en = 1'b1;
                ctl.is_host = 1'b1;
            end
            A_SEND_RESUME: begin
                ctl.host_en      = 1'b1;
                ctl.is_host      = 1'b1;
                ctl.drive_resume = 1'b1;
            end
            A_AS_DEVICE: begin
                ctl.dp_pullup = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_A_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == A_HOST_IDLE && enable && qualified && line_disc && a_yield)
        |=> (!ctl.host_en && ctl.dp_pullup)); // R3

    AST_A_UNQUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == A_HOST_IDLE && !qualified)
        |=> (ctl.host_en && !ctl.dp_pullup)); // R5

    AST_A_RESUME_AS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.drive_resume |-> ctl.host_en); // R4

endmodule

// File: rtl/otg_b_side.sv
module otg_b_side
    import otg_role_pkg::*;
#(
    parameter int TW          = 7,
    parameter int RESET_MS    = 10,
    parameter int CONN_TMO_MS = 100
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      qualified,
    input  logic      b_req,
    input  logic      line_conn,
    input  logic      line_resume,
    input  logic      ms_tick,
    output line_ctl_t ctl
);
    typedef struct packed {
        b_state_e st;
    } b_reg_t;

    b_reg_t        s_d, s_q;
    logic          tmr_run, tmr_clr, tmr_done;
    logic [TW-1:0] tmr_limit;

    assign tmr_run   = (s_q.st == B_AWAIT_CONN) || (s_q.st == B_BUS_RESET);
    assign tmr_clr   = (s_d.st != s_q.st);
    assign tmr_limit = (s_q.st == B_BUS_RESET) ? TW'(RESET_MS) : TW'(CONN_TMO_MS);

    otg_ms_timer #(.TW(TW)) i_b_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .clr    (tmr_clr),
        .tick   (ms_tick),
        .limit  (tmr_limit),
        .expire (tmr_done)
    );

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.st = B_AS_DEVICE;
        end else begin
            case (s_q.st)
                B_AS_DEVICE: begin
                    if (b_req && qualified) s_d.st = B_AWAIT_CONN;
                end
                B_AWAIT_CONN: begin
                    // connect outranks both resume and timeout
                    if (line_conn)        s_d.st = B_BUS_RESET;
                    else if (line_resume) s_d.st = B_AS_DEVICE;
                    else if (tmr_done)    s_d.st = B_AS_DEVICE;
                end
                B_BUS_RESET: begin
                    if (tmr_done) s_d.st = B_AS_HOST;
                end
                B_AS_HOST: s_d.st = B_AS_HOST;
                default:   s_d.st = B_AS_DEVICE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= B_AS_DEVICE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ctl = '0;
        case (s_q.st)
            B_AS_DEVICE:  ctl.dp_pullup = 1'b1;
            B_AWAIT_CONN: ctl = '0;
            B_BUS_RESET: begin
                ctl.host_en     = 1'b1;
                ctl.is_host     = 1'b1;
                ctl.drive_reset = 1'b1;
            end
            B_AS_HOST: begin
                ctl.host_en = 1'b1;
                ctl.is_host = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_B_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $fell(ctl.dp_pullup)) |-> $past(enable && qualified && b_req)); // R2

    AST_B_RESET_AS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.drive_reset |-> (ctl.host_en && !ctl.dp_pullup)); // R6

    AST_B_CONN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == B_AWAIT_CONN && enable && line_conn) |=> ctl.drive_reset); // R10

    AST_B_RESUME_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == B_AWAIT_CONN && enable && !line_conn && line_resume)
        |=> ctl.dp_pullup); // R8

endmodule

// File: rtl/otg_role_swap.sv
module otg_role_swap
    import otg_role_pkg::*;
#(
    parameter int RESET_MS    = 10,
    parameter int CONN_TMO_MS = 100,
    parameter int RESUME_MS   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_role_b,
    input  logic hnp_en,
    input  logic suspended,
    input  logic full_speed,
    input  logic ms_tick,
    input  logic b_req,
    input  logic a_yield,
    input  logic line_disc,
    input  logic line_conn,
    input  logic line_resume,
    output logic host_en,
    output logic dp_pullup,
    output logic drive_reset,
    output logic drive_resume,
    output logic is_host
);
    localparam int B_MAX_MS = (RESET_MS > CONN_TMO_MS) ? RESET_MS : CONN_TMO_MS;
    localparam int B_TW     = $clog2(B_MAX_MS + 1);
    localparam int A_TW     = $clog2(RESUME_MS + 1);

    logic      qualified;
    line_ctl_t a_ctl, b_ctl, sel_ctl;

    assign qualified = hnp_en && suspended && full_speed;

    otg_a_side #(.TW(A_TW), .RESUME_MS(RESUME_MS)) i_a_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!cfg_role_b),
        .qualified (qualified),
        .line_disc (line_disc),
        .a_yield   (a_yield),
        .ms_tick   (ms_tick),
        .ctl       (a_ctl)
    );

    otg_b_side #(.TW(B_TW), .RESET_MS(RESET_MS), .CONN_TMO_MS(CONN_TMO_MS)) i_b_side (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (cfg_role_b),
        .qualified   (qualified),
        .b_req       (b_req),
        .line_conn   (line_conn),
        .line_resume (line_resume),
        .ms_tick     (ms_tick),
        .ctl         (b_ctl)
    );

    assign sel_ctl      = cfg_role_b ? b_ctl : a_ctl;
    assign host_en      = sel_ctl.host_en;
    assign dp_pullup    = sel_ctl.dp_pullup;
    assign drive_reset  = sel_ctl.drive_reset;
    assign drive_resume = sel_ctl.drive_resume;
    assign is_host      = sel_ctl.is_host;

    AST_ROLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        is_host == host_en); // R9

    AST_HOST_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        host_en |-> !dp_pullup); // R9

endmodule

// File: tb/test_otg_role_swap.sv
module test_otg_role_swap;

    localparam int T_RESET = 3;
    localparam int T_TMO   = 5;
    localparam int T_RES   = 2;

    // Expected vectors {host_en, dp_pullup, drive_reset, drive_resume, is_host}
    localparam logic [4:0] V_A_HOST   = 5'b10001;
    localparam logic [4:0] V_A_RESUME = 5'b10011;
    localparam logic [4:0] V_A_DEV    = 5'b01000;
    localparam logic [4:0] V_B_DEV    = 5'b01000;
    localparam logic [4:0] V_B_WAIT   = 5'b00000;
    localparam logic [4:0] V_B_RESET  = 5'b10101;
    localparam logic [4:0] V_B_HOST   = 5'b10001;

    logic clk = 1'b0;
    logic rst_n, cfg_role_b, hnp_en, suspended, full_speed, ms_tick;
    logic b_req, a_yield, line_disc, line_conn, line_resume;
    logic host_en, dp_pullup, drive_reset, drive_resume, is_host;
    logic [4:0] outv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    assign outv = {host_en, dp_pullup, drive_reset, drive_resume, is_host};

    otg_role_swap #(.RESET_MS(T_RESET), .CONN_TMO_MS(T_TMO), .RESUME_MS(T_RES)) i_otg_role_swap (
        .clk(clk), .rst_n(rst_n), .cfg_role_b(cfg_role_b), .hnp_en(hnp_en),
        .suspended(suspended), .full_speed(full_speed), .ms_tick(ms_tick),
        .b_req(b_req), .a_yield(a_yield), .line_disc(line_disc),
        .line_conn(line_conn), .line_resume(line_resume), .host_en(host_en),
        .dp_pullup(dp_pullup), .drive_reset(drive_reset),
        .drive_resume(drive_resume), .is_host(is_host)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic tick_ms();
        ms_tick = 1'b1;
        step();
        ms_tick = 1'b0;
    endtask

    task automatic check(input string tag, input logic [4:0] exp);
        n_chk++;
        if (outv !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, outv, exp);
        end
    endtask

    task automatic do_reset(input logic role_b);
        {hnp_en, suspended, full_speed, ms_tick, b_req, a_yield} = '0;
        {line_disc, line_conn, line_resume} = '0;
        cfg_role_b = role_b;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic b_request();
        {hnp_en, suspended, full_speed, b_req} = 4'b1111;
        step();
        b_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset states of both sides
        do_reset(1'b0);
        check("R1 A reset", V_A_HOST);
        do_reset(1'b1);
        check("R1 B reset", V_B_DEV);

        // R2 sweep qualifiers and request on the B side
        for (int i = 0; i < 16; i++) begin
            do_reset(1'b1);
            {hnp_en, suspended, full_speed, b_req} = 4'(i);
            step();
            check("R2 B request gate", (i == 15) ? V_B_WAIT : V_B_DEV);
        end

        // R3/R5 sweep qualifiers on an A side disconnect with yield
        for (int i = 0; i < 8; i++) begin
            do_reset(1'b0);
            {hnp_en, suspended, full_speed} = 3'(i);
            a_yield   = 1'b1;
            line_disc = 1'b1;
            step();
            line_disc = 1'b0;
            check((i == 7) ? "R3 A hands over" : "R5 A ignores disconnect",
                  (i == 7) ? V_A_DEV : V_A_HOST);
        end

        // R4 A keeps host by resume
        do_reset(1'b0);
        {hnp_en, suspended, full_speed} = 3'b111;
        a_yield   = 1'b0;
        line_disc = 1'b1;
        step();
        line_disc = 1'b0;
        check("R4 resume start", V_A_RESUME);
        for (int k = 1; k < T_RES; k++) begin
            tick_ms();
            check("R4 resume held", V_A_RESUME);
        end
        tick_ms();
        check("R4 resume end", V_A_HOST);

        // R7 connect timeout
        do_reset(1'b1);
        b_request();
        for (int k = 1; k < T_TMO; k++) tick_ms();
        check("R7 before timeout", V_B_WAIT);
        tick_ms();
        check("R7 at timeout", V_B_DEV);

        // R8 resume while waiting
        do_reset(1'b1);
        b_request();
        tick_ms();
        line_resume = 1'b1;
        step();
        line_resume = 1'b0;
        check("R8 resume seen", V_B_DEV);

        // R6 connect then bus reset
        do_reset(1'b1);
        b_request();
        tick_ms();
        tick_ms();
        line_conn = 1'b1;
        step();
        line_conn = 1'b0;
        check("R6 reset start", V_B_RESET);
        for (int k = 1; k < T_RESET; k++) begin
            tick_ms();
            check("R6 reset held", V_B_RESET);
        end
        tick_ms();
        check("R6 reset end", V_B_HOST);
        n_chk++;
        if (is_host !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 role bit: got %b expected 1", is_host);
        end

        // R10 connect on the final timeout tick
        do_reset(1'b1);
        b_request();
        for (int k = 1; k < T_TMO; k++) tick_ms();
        ms_tick   = 1'b1;
        line_conn = 1'b1;
        step();
        ms_tick   = 1'b0;
        line_conn = 1'b0;
        check("R10 connect wins", V_B_RESET);
        for (int k = 1; k < T_RESET; k++) tick_ms();
        check("R10 full reset period", V_B_RESET);
        tick_ms();
        check("R10 host after reset", V_B_HOST);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule